// File: doc/BRIEF.md
# I2S to Simultaneous-Mode Multibit DAC Formatter

This block accepts a stereo I2S stream carrying 16-bit words and turns each left/right pair into a burst for a multibit DAC that loads both channels at once. The left word goes out on one serial line and the right word on a second line. Both lines share one output bit clock and are sampled on the same rising edge. After the burst, a latch pulse tells the DAC to move the shifted pair to its converters. Between bursts the output bit clock rests low, so the DAC input sees a stopped clock rather than a free-running one.

All logic runs on a single master clock `clk`. The I2S bit clock, word select and data are brought into this domain through a chain of synchronising flops, and their edges are found there. For this reason the master clock must be several times faster than the incoming bit clock. Each I2S frame is measured from one falling word-select edge to the next. When the length is wrong, the block raises a loss-of-lock flag and silences the DAC side. It resumes only after the input has delivered a run of well-formed frames.

Top module: `i2s_simul_dac_fmt`

## Requirements
- R1: While reset is asserted and right after it is released, `dac_bclk`, `dac_data_l`, `dac_data_r` and `dac_latch` are 0 and `sync_lost` is 1.
- R2: Input words are taken MSB first on rising `i2s_bck` edges with a one-bit delay: the MSB of a word is the bit sampled on the second rising edge after `i2s_ws` changes. Words taken while `i2s_ws` = 0 are left, and words taken while `i2s_ws` = 1 are right.
- R3: Each accepted pair produces exactly 16 rising edges of `dac_bclk` before its latch pulse. On each rising edge, `dac_data_l` and `dac_data_r` carry the same bit position of the left and right word, starting at the MSB.
- R4: `dac_data_l` and `dac_data_r` change only while `dac_bclk` is low, so their value at each rising edge equals their value in the master cycle before it.
- R5: After the 16th bit, `dac_bclk` stays low. `dac_latch` rises in the second master cycle after the last cycle in which `dac_bclk` was high, stays high for exactly 2 master cycles, and `dac_bclk` is low for the whole pulse.
- R6: A frame is good when exactly 32 rising input bit-clock edges separate consecutive falling edges of `i2s_ws`. The first falling edge after reset only starts the measurement. When a frame closes with a different count, or when a 33rd edge arrives before the closing falling edge, `sync_lost` goes to 1 and all four DAC outputs are held at 0 while it stays set.
- R7: `sync_lost` clears when the second consecutive good frame closes. The pair of that second good frame is the first pair sent after the loss. From then on, one pair is sent for every further good frame.
- R8: Only matched pairs are sent. A pair is the left and right word of the same frame, taken when that frame's right word completes, and the pair of a frame that fails the length check is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i2s_bck | input | 1 | Incoming I2S bit clock (asynchronous) |
| i2s_ws | input | 1 | Incoming I2S word select, 0 = left |
| i2s_sd | input | 1 | Incoming I2S serial data |
| dac_bclk | output | 1 | Stopped output bit clock shared by both data lines |
| dac_data_l | output | 1 | Left channel serial data, MSB first |
| dac_data_r | output | 1 | Right channel serial data, MSB first |
| dac_latch | output | 1 | Latch pulse, one rising edge per pair |
| sync_lost | output | 1 | 1 while the input frame timing is not trusted |

## Verification
Two events fall on the same input bit-clock edge: the closing of a frame's length check and the completion of that frame's right word. One edge therefore decides both the lock state and whether the pair is released. The bench provokes this by inserting frames of 30 and 34 slots between good frames, then watching which pairs reach the DAC lines. The pair closed at the start of the bad frame must appear, the bad frame's pair and the first good pair after it must not, and the second good pair must appear just as the flag clears.

// File: rtl/dacfmt_pkg.sv
package dacfmt_pkg;

  typedef enum logic [1:0] {
    EM_IDLE  = 2'd0,
    EM_SHIFT = 2'd1,
    EM_GAP   = 2'd2,
    EM_LATCH = 2'd3
  } emit_state_t;

  // True when the edge count of a closed frame equals the nominal length.
  function automatic logic frame_len_ok(input int unsigned edges,
                                        input int unsigned frame_bits);
    return edges == frame_bits;
  endfunction

  // Saturating increment of the good-frame run counter.
  function automatic int unsigned run_step(input int unsigned run,
                                           input int unsigned limit);
    return (run >= limit) ? limit : run + 1;
  endfunction

  // Bit of a word sent in slot idx, MSB leaving first.
  function automatic logic msb_first_bit(input logic [31:0] word,
                                         input int unsigned width,
                                         input int unsigned idx);
    return word[width - 1 - idx];
  endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= g_stage[s-1].r;
      end
    end
  end

  assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/i2s_deframer.sv
module i2s_deframer
  import dacfmt_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int GOOD_NEED = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bck_s,
  input  logic              ws_s,
  input  logic              sd_s,
  output logic [WORD_W-1:0] pair_l,
  output logic [WORD_W-1:0] pair_r,
  output logic              pair_accept,
  output logic              pair_strobe,
  output logic              frame_fault,
  output logic              sync_lost
);

  localparam int FRAME_BITS = 2 * WORD_W;
  localparam int CW         = $clog2(FRAME_BITS + 2);
  localparam int RW         = $clog2(GOOD_NEED + 1);

  logic              bck_d, ws_last, seen;
  logic [WORD_W-1:0] shreg, left_q;
  logic [CW-1:0]     cnt;
  logic [RW-1:0]     run, run_nxt;
  logic              lost_nxt;

  // Named events for the checker and for readability.
  logic              bck_rise, ws_edge, fall_edge, close_good, close_bad, overrun;
  logic [WORD_W-1:0] word_now;

  assign bck_rise   = bck_s & ~bck_d;
  assign ws_edge    = bck_rise & (ws_s != ws_last);
  assign fall_edge  = ws_edge & ws_last;
  assign word_now   = {shreg[WORD_W-2:0], sd_s};
  assign close_good = fall_edge & seen & frame_len_ok(int'(cnt), FRAME_BITS);
  assign close_bad  = fall_edge & seen & ~frame_len_ok(int'(cnt), FRAME_BITS);
  assign overrun    = bck_rise & ~ws_edge & seen & (cnt == CW'(FRAME_BITS));
  assign frame_fault = close_bad | overrun;

  always_comb begin
    run_nxt = run;
    if (frame_fault)     run_nxt = '0;
    else if (close_good) run_nxt = RW'(run_step(int'(run), GOOD_NEED));
  end

  assign pair_accept = close_good & (run_nxt >= RW'(GOOD_NEED));

  always_comb begin
    lost_nxt = sync_lost;
    if (frame_fault)      lost_nxt = 1'b1;
    else if (pair_accept) lost_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_d       <= 1'b0;
      ws_last     <= 1'b0;
      seen        <= 1'b0;
      shreg       <= '0;
      left_q      <= '0;
      cnt         <= '0;
      run         <= '0;
      sync_lost   <= 1'b1;
      pair_l      <= '0;
      pair_r      <= '0;
      pair_strobe <= 1'b0;
    end else begin
      bck_d       <= bck_s;
      run         <= run_nxt;
      sync_lost   <= lost_nxt;
      pair_strobe <= pair_accept;
      if (bck_rise) begin
        shreg   <= word_now;
        ws_last <= ws_s;
        if (ws_edge && !ws_last) left_q <= word_now;
        if (fall_edge) begin
          seen <= 1'b1;
          cnt  <= CW'(1);
        end else if (cnt <= CW'(FRAME_BITS)) begin
          cnt <= cnt + 1'b1;
        end
      end
      if (pair_accept) begin
        pair_l <= left_q;
        pair_r <= word_now;
      end
    end
  end

endmodule

// File: rtl/simul_emitter.sv
module simul_emitter
  import dacfmt_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int LE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              abort,
  input  logic [WORD_W-1:0] word_l,
  input  logic [WORD_W-1:0] word_r,
  output logic              bclk,
  output logic              data_l,
  output logic              data_r,
  output logic              latch,
  output logic              busy
);

  localparam int PW  = $clog2(2 * WORD_W);
  localparam int LCW = $clog2(LE_CYCLES + 1);

  emit_state_t       state;
  logic [PW-1:0]     phase;
  logic [LCW-1:0]    le_cnt;
  logic [WORD_W-1:0] sh_l, sh_r;
  logic              pending, start;
  logic [PW-2:0]     bit_idx;

  assign start   = (state == EM_IDLE) & pending & ~abort;
  assign bit_idx = phase[PW-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= EM_IDLE;
      phase   <= '0;
      le_cnt  <= '0;
      sh_l    <= '0;
      sh_r    <= '0;
      pending <= 1'b0;
    end else if (abort) begin
      state   <= EM_IDLE;
      phase   <= '0;
      le_cnt  <= '0;
      pending <= 1'b0;
    end else begin
      if (load && !start)  pending <= 1'b1;
      else if (start)      pending <= 1'b0;
      unique case (state)
        EM_IDLE: if (start) begin
          state <= EM_SHIFT;
          phase <= '0;
          sh_l  <= word_l;
          sh_r  <= word_r;
        end
        EM_SHIFT: begin
          phase <= phase + 1'b1;
          if (phase == PW'(2 * WORD_W - 1)) state <= EM_GAP;
        end
        EM_GAP: begin
          state  <= EM_LATCH;
          le_cnt <= '0;
        end
        EM_LATCH: begin
          le_cnt <= le_cnt + 1'b1;
          if (le_cnt == LCW'(LE_CYCLES - 1)) state <= EM_IDLE;
        end
        default: state <= EM_IDLE;
      endcase
    end
  end

  assign bclk   = (state == EM_SHIFT) & phase[0];
  assign data_l = (state == EM_SHIFT) & msb_first_bit(32'(sh_l), WORD_W, int'(bit_idx));
  assign data_r = (state == EM_SHIFT) & msb_first_bit(32'(sh_r), WORD_W, int'(bit_idx));
  assign latch  = (state == EM_LATCH);
  assign busy   = (state != EM_IDLE);

endmodule

// File: rtl/i2s_simul_dac_fmt.sv
module i2s_simul_dac_fmt #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int GOOD_NEED   = 2,
  parameter int LE_CYCLES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic i2s_bck,
  input  logic i2s_ws,
  input  logic i2s_sd,
  output logic dac_bclk,
  output logic dac_data_l,
  output logic dac_data_r,
  output logic dac_latch,
  output logic sync_lost
);

  logic [2:0]        raw_in, sync_in;
  logic [WORD_W-1:0] pair_l, pair_r;
  logic              pair_accept, pair_strobe, frame_fault, emit_busy;

  assign raw_in = {i2s_bck, i2s_ws, i2s_sd};

  sync_chain #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
  );

  i2s_deframer #(.WORD_W(WORD_W), .GOOD_NEED(GOOD_NEED)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .bck_s(sync_in[2]), .ws_s(sync_in[1]), .sd_s(sync_in[0]),
    .pair_l(pair_l), .pair_r(pair_r),
    .pair_accept(pair_accept), .pair_strobe(pair_strobe),
    .frame_fault(frame_fault), .sync_lost(sync_lost)
  );

  simul_emitter #(.WORD_W(WORD_W), .LE_CYCLES(LE_CYCLES)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load(pair_strobe), .abort(frame_fault),
    .word_l(pair_l), .word_r(pair_r),
    .bclk(dac_bclk), .data_l(dac_data_l), .data_r(dac_data_r),
    .latch(dac_latch), .busy(emit_busy)
  );

endmodule

// File: rtl/fmt_checker.sv
module fmt_checker #(
  parameter int WORD_W    = 16,
  parameter int LE_CYCLES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic dac_bclk,
  input logic dac_data_l,
  input logic dac_data_r,
  input logic dac_latch,
  input logic sync_lost,
  input logic pair_accept
);

  logic       bclk_q, latch_q;
  logic [7:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      latch_q <= 1'b0;
      rises   <= '0;
    end else begin
      bclk_q  <= dac_bclk;
      latch_q <= dac_latch;
      if (sync_lost || (dac_latch && !latch_q)) rises <= '0;
      else if (dac_bclk && !bclk_q)             rises <= rises + 1'b1;
    end
  end

  // R4: data lines hold still across every rising output clock edge
  p_data_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_bclk) |-> ($stable(dac_data_l) && $stable(dac_data_r)));

  // R5: one quiet cycle between the last clock high and the latch
  p_latch_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_latch) |-> (!dac_bclk && !$past(dac_bclk) && $past(dac_bclk, 2)));

  // R5: latch pulse is at least two cycles wide
  p_latch_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_latch) |-> ($past(dac_latch) && $past(dac_latch, 2)));

  // R5: no output clock while the latch is high
  p_latch_no_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dac_latch |-> !dac_bclk);

  // R3: a full burst of WORD_W clock rises precedes each latch
  p_burst_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_latch && !latch_q) |-> (rises == 8'(WORD_W)));

  // R6: outputs silent while lock is lost
  p_quiet_lost_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> (!dac_bclk && !dac_data_l && !dac_data_r && !dac_latch));

  // R7: releasing a pair means lock is held on the next cycle
  p_accept_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_accept |=> !sync_lost);

endmodule

bind i2s_simul_dac_fmt fmt_checker #(.WORD_W(WORD_W), .LE_CYCLES(LE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .dac_bclk(dac_bclk), .dac_data_l(dac_data_l), .dac_data_r(dac_data_r),
  .dac_latch(dac_latch), .sync_lost(sync_lost), .pair_accept(pair_accept)
);

// File: tb/tb_i2s_simul_dac_fmt.sv
`timescale 1ns/1ps
module tb_i2s_simul_dac_fmt;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic dac_bclk, dac_l, dac_r, dac_le, lost;

  always #4 clk = ~clk;

  i2s_simul_dac_fmt dut (
    .clk(clk), .rst_n(rst_n),
    .i2s_bck(bck), .i2s_ws(ws), .i2s_sd(sd),
    .dac_bclk(dac_bclk), .dac_data_l(dac_l), .dac_data_r(dac_r),
    .dac_latch(dac_le), .sync_lost(lost)
  );

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected and received pairs
  logic [15:0] exp_l[64], exp_r[64], rec_l[64], rec_r[64];
  int n_exp = 0, n_rec = 0;

  // Bench model of frame lock
  bit started = 0, b_seen = 0;
  int b_run = 0, prev_len = 0;
  logic [15:0] prev_l = 0, prev_r = 0;
  logic prev_lsb = 1'b0;

  // Output monitor
  logic bclk_h1 = 0, bclk_h2 = 0, dl_h1 = 0, dr_h1 = 0, le_h1 = 0;
  logic [15:0] cap_l = 0, cap_r = 0;
  int nbits = 0, le_len = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (lost)
        check(!(dac_bclk | dac_l | dac_r | dac_le), "R6", "outputs while lost",
              {dac_bclk, dac_l, dac_r, dac_le}, 0);
      if (dac_bclk && !bclk_h1) begin
        check(dac_l == dl_h1 && dac_r == dr_h1, "R4", "data moved at clock rise",
              {dac_l, dac_r}, {dl_h1, dr_h1});
        cap_l = {cap_l[14:0], dac_l};
        cap_r = {cap_r[14:0], dac_r};
        nbits++;
      end
      if (dac_le) begin
        check(!dac_bclk, "R5", "clock during latch", dac_bclk, 0);
        le_len++;
      end
      if (dac_le && !le_h1) begin
        check(nbits == 16, "R3", "bits before latch", nbits, 16);
        check(!bclk_h1 && bclk_h2, "R5", "latch gap history", {bclk_h2, bclk_h1}, 2);
        if (n_rec < 64) begin
          rec_l[n_rec] = cap_l;
          rec_r[n_rec] = cap_r;
          n_rec++;
        end
        nbits = 0;
      end
      if (!dac_le && le_h1) begin
        check(le_len == 2, "R5", "latch width", le_len, 2);
        le_len = 0;
      end
      if (lost) nbits = 0;
    end
    bclk_h2 = bclk_h1;
    bclk_h1 = dac_bclk;
    dl_h1 = dac_l;
    dr_h1 = dac_r;
    le_h1 = dac_le;
  end

  task automatic model_close();
    if (!b_seen) begin
      b_seen = 1;
    end else if (prev_len == 32) begin
      if (b_run < 2) b_run++;
      if (b_run == 2 && n_exp < 64) begin
        exp_l[n_exp] = prev_l;
        exp_r[n_exp] = prev_r;
        n_exp++;
      end
    end else begin
      b_run = 0;
    end
  endtask

  // One frame of len slots; len == 32 carries the given pair (R2 framing)
  task automatic send_frame(input logic [15:0] l, input logic [15:0] r, input int len);
    if (started) model_close();
    started = 1;
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      bck = 1'b0;
      ws  = (i >= len / 2);
      if (i == 0)           sd = prev_lsb;
      else if (len != 32)   sd = 1'b0;
      else if (i <= 16)     sd = l[16 - i];
      else                  sd = r[32 - i];
      repeat (4) @(negedge clk);
      bck = 1'b1;
      repeat (4) @(negedge clk);
    end
    prev_lsb = (len == 32) ? r[0] : 1'b0;
    prev_len = len;
    prev_l = l;
    prev_r = r;
  endtask

  task automatic clear_lists();
    n_exp = 0;
    n_rec = 0;
  endtask

  task automatic compare_lists(input string req);
    check(n_rec == n_exp, req, "pair count", n_rec, n_exp);
    for (int i = 0; i < n_exp && i < n_rec; i++) begin
      check(rec_l[i] == exp_l[i], req, "left word", rec_l[i], exp_l[i]);
      check(rec_r[i] == exp_r[i], req, "right word", rec_r[i], exp_r[i]);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check({dac_bclk, dac_l, dac_r, dac_le} == 0, "R1", "outputs in reset",
          {dac_bclk, dac_l, dac_r, dac_le}, 0);
    check(lost == 1'b1, "R1", "lost in reset", lost, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check({dac_bclk, dac_l, dac_r, dac_le} == 0, "R1", "outputs after reset",
          {dac_bclk, dac_l, dac_r, dac_le}, 0);
    check(lost == 1'b1, "R1", "lost after reset", lost, 1);
  endtask

  task automatic t_lock();
    clear_lists();
    send_frame(16'h1111, 16'h2222, 32);
    send_frame(16'h3333, 16'h4444, 32);
    send_frame(16'h5A5A, 16'hA5A5, 32);
    check(lost == 1'b1, "R7", "lost after one good frame", lost, 1);
    send_frame(16'h7E81, 16'h817E, 32);
    check(lost == 1'b0, "R7", "lock after two good frames", lost, 0);
    compare_lists("R7");
  endtask

  task automatic t_stream();
    clear_lists();
    send_frame(16'h8000, 16'h0001, 32);
    send_frame(16'hFFFF, 16'h0000, 32);
    send_frame(16'h0000, 16'hFFFF, 32);
    send_frame(16'hA5C3, 16'h3C5A, 32);
    send_frame(16'h1234, 16'hFEDC, 32);
    check(lost == 1'b0, "R2", "lock held in stream", lost, 0);
    compare_lists("R3");
  endtask

  task automatic t_bad(input int len, input string tag);
    clear_lists();
    send_frame(16'hC001, 16'h0C01, 32);
    send_frame(16'hDEAD, 16'hBEEF, len);
    send_frame(16'h1357, 16'h2468, 32);
    check(lost == 1'b1, "R6", {tag, " lost after bad frame"}, lost, 1);
    send_frame(16'h9ABC, 16'hDEF0, 32);
    check(lost == 1'b1, "R7", {tag, " still lost after one good"}, lost, 1);
    send_frame(16'h0F0F, 16'hF0F0, 32);
    check(lost == 1'b0, "R7", {tag, " relock"}, lost, 0);
    compare_lists("R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_lock();
    t_stream();
    t_bad(30, "short");
    t_bad(34, "long");
    repeat (80) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule